// File: doc/BRIEF.md
# Serial Register Streaming Port

This block is a serial-bus slave with four wires that gives a master access to a register file. The slave side is one clock domain. Each transaction starts when the select line goes low. The master then shifts in one 16-bit command word. Its top five bits must carry a fixed key. Below the key sits one direction bit, and the low ten bits give a starting register address.

For a read, the block fetches registers from its register-file port and streams them out on the serial data output, one 16-bit word after another, with the address going up by one per word. It keeps streaming until the master raises the select line. For a write, every further 16-bit word the master shifts in is stored at the current address, which then steps forward.

The serial inputs are sampled into the system clock domain through synchronizers, so each SCLK high phase and each low phase must last at least 8 system clock cycles. The register file is expected to return read data one clock after a read strobe. The output enable is meant to drive an external three-state pad.

Top module: `spi_rb_slave`

## Requirements
- R1: A command word is 16 bits taken MSB first on the serial input at SCLK rising edges. Bits [15:11] hold the key, bit [10] is the direction (1 = read, 0 = write) and bits [9:0] hold the start address.
- R2: A command whose key differs from binary 11100 is discarded. Until the select line rises, the block then performs no register write and no register read, and it leaves the output enable low.
- R3: After a read command for address A, the serial output carries the contents of A, A+1, A+2 and so on. Each word is sent MSB first, and each bit is driven after an SCLK falling edge, so it is valid at the next rising edge.
- R4: The output enable stays low while the command word is being received and whenever the select line is high.
- R5: Data on the serial input during a read stream causes no register write.
- R6: After a write command for address A, the k-th complete 16-bit data word is written to address A+k-1. A word left incomplete when the select line rises is not written.
- R7: The register address wraps from 0x3FF to 0x000, for both reads and writes.
- R8: Lowering the select line restarts the bit count, so a partial command from an aborted frame has no effect on the next frame.
- R9: After reset the output enable, read strobe and write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select line, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from the master, idle low |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Enable for the three-state serial output pad |
| rf_addr | output | 10 | Register-file address |
| rf_re | output | 1 | Register-file read strobe, data expected one clock later |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data |

## Verification
The bench streams reads that cross the top of the address space. A design without wrap would return the word from the wrong register after 0x3FF. Writes are also placed across the top, where a missing wrap would corrupt a different register. Frames with a wrong key are sent in both directions, so a decoder that ignored the key would drive the output or change registers. A frame is aborted after nine command bits, and a counter not cleared on select would then misread the next command. A write frame is cut short mid-word, where a block that stored partial words would overwrite memory. Throughout the read streams the serial input is held high, so a block that kept decoding writes would alter the registers it was reading.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int KEY_W = 5;
  localparam logic [KEY_W-1:0] KEY_VAL = 5'b11100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_WRITE,
    ST_IGNORE
  } st_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
      logic [STAGES:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){RST_VAL[g]}};
        else     chain <= {chain[STAGES-1:0], din[g]};
      end
      assign lvl[g]  = chain[STAGES-1];
      assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
      assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/spi_rb_rx.sv
module spi_rb_rx #(
  parameter int RXW = 16,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            sdi_bit,
  input  logic [CNTW-1:0] len_m1,
  output logic [RXW-1:0]  word,
  output logic            done
);
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= 1'b0;
      if (shift_en) begin
        word <= {word[RXW-2:0], sdi_bit};
        if (cnt == len_m1) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          sclk_fall,
  input  logic          ld_cur,
  input  logic          ld_nxt,
  input  logic [DW-1:0] rdata,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          swap
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] TOP = IW'(DW - 1);

  logic [DW-1:0] cur_word;
  logic [DW-1:0] nxt_word;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      idx    <= TOP;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      swap   <= 1'b0;
    end else begin
      swap <= 1'b0;
      if (sclk_fall) begin
        sdo_oe <= 1'b1;
        sdo    <= cur_word[idx];
        if (idx == '0) begin
          idx  <= TOP;
          swap <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  // data registers: no reset needed, always loaded before use
  always_ff @(posedge clk) begin
    if (ld_cur) cur_word <= rdata;
    else if (active && sclk_fall && idx == '0) cur_word <= nxt_word;
    if (ld_nxt) nxt_word <= rdata;
  end
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
  import spi_rb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int RXW = 16,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_act,
  input  logic            cs_start,
  input  logic            rx_done,
  input  logic [RXW-1:0]  rx_word,
  input  logic            tx_swap,
  output st_t             st,
  output logic [CNTW-1:0] len_m1,
  output logic [AW-1:0]   rf_addr,
  output logic            rf_re,
  output logic            rf_we,
  output logic [DW-1:0]   rf_wdata,
  output logic            ld_cur,
  output logic            ld_nxt
);
  logic [AW-1:0] ptr;
  logic          p0_v, p0_nxt, p1_v, p1_nxt;

  logic [KEY_W-1:0] cmd_key;
  logic             cmd_rd;
  logic [AW-1:0]    cmd_addr;

  assign cmd_key  = rx_word[CW-1 -: KEY_W];
  assign cmd_rd   = rx_word[AW];
  assign cmd_addr = rx_word[AW-1:0];

  assign len_m1 = (st == ST_CMD) ? CNTW'(CW - 1) : CNTW'(DW - 1);
  assign ld_cur = p1_v & ~p1_nxt;
  assign ld_nxt = p1_v & p1_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      rf_addr  <= '0;
      rf_re    <= 1'b0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
      p0_v     <= 1'b0;
      p0_nxt   <= 1'b0;
      p1_v     <= 1'b0;
      p1_nxt   <= 1'b0;
    end else begin
      rf_re  <= 1'b0;
      rf_we  <= 1'b0;
      p1_v   <= p0_v;
      p1_nxt <= p0_nxt;
      p0_v   <= 1'b0;
      if (!cs_act) begin
        st   <= ST_IDLE;
        p0_v <= 1'b0;
        p1_v <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (cs_start) st <= ST_CMD;
          ST_CMD: begin
            if (rx_done) begin
              if (cmd_key != KEY_VAL) begin
                st <= ST_IGNORE;
              end else if (cmd_rd) begin
                st      <= ST_READ;
                rf_addr <= cmd_addr;
                rf_re   <= 1'b1;
                ptr     <= cmd_addr + 1'b1;
                p0_v    <= 1'b1;
                p0_nxt  <= 1'b0;
              end else begin
                st  <= ST_WRITE;
                ptr <= cmd_addr;
              end
            end
          end
          ST_READ: begin
            if (ld_cur || tx_swap) begin
              rf_addr <= ptr;
              rf_re   <= 1'b1;
              ptr     <= ptr + 1'b1;
              p0_v    <= 1'b1;
              p0_nxt  <= 1'b1;
            end
          end
          ST_WRITE: begin
            if (rx_done) begin
              rf_addr  <= ptr;
              rf_we    <= 1'b1;
              rf_wdata <= rx_word[DW-1:0];
              ptr      <= ptr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
  import spi_rb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] rf_addr,
  output logic          rf_re,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int CW   = KEY_W + 1 + AW;
  localparam int RXW  = (CW > DW) ? CW : DW;
  localparam int CNTW = $clog2(RXW);

  logic [2:0] s_lvl, s_rise, s_fall;
  logic       cs_act, cs_start, sclk_rise, sclk_fall;
  logic       unused_edges;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .din({sdi, sclk, cs_n}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign cs_act       = ~s_lvl[0];
  assign cs_start     = s_fall[0];
  assign sclk_rise    = s_rise[1] & cs_act;
  assign sclk_fall    = s_fall[1] & cs_act;
  assign unused_edges = ^{s_rise[2], s_fall[2], s_rise[0]};

  st_t             st_q;
  logic [CNTW-1:0] len_m1;
  logic [RXW-1:0]  rx_word;
  logic            rx_done, tx_swap, ld_cur, ld_nxt, rx_shift;

  assign rx_shift = sclk_rise & ((st_q == ST_CMD) | (st_q == ST_WRITE));

  spi_rb_rx #(.RXW(RXW), .CNTW(CNTW)) u_rx (
    .clk(clk), .rst(rst), .clear(cs_start), .shift_en(rx_shift),
    .sdi_bit(s_lvl[2]), .len_m1(len_m1), .word(rx_word), .done(rx_done)
  );

  spi_rb_ctrl #(.AW(AW), .DW(DW), .CW(CW), .RXW(RXW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_start(cs_start),
    .rx_done(rx_done), .rx_word(rx_word), .tx_swap(tx_swap),
    .st(st_q), .len_m1(len_m1), .rf_addr(rf_addr), .rf_re(rf_re),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .ld_cur(ld_cur), .ld_nxt(ld_nxt)
  );

  spi_rb_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .active((st_q == ST_READ) & cs_act),
    .sclk_fall(sclk_fall), .ld_cur(ld_cur), .ld_nxt(ld_nxt),
    .rdata(rf_rdata), .sdo(sdo), .sdo_oe(sdo_oe), .swap(tx_swap)
  );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker
  import spi_rb_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cs_act,
  input st_t  st,
  input logic rf_re,
  input logic rf_we,
  input logic sdo_oe
);
  // R4: output driven only while a read stream is running
  p_oe_in_read_r4: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> st == ST_READ);

  // R4: select released -> output floats on the next cycle
  p_idle_float_r4: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_oe);

  // R2: a rejected frame touches nothing
  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    st == ST_IGNORE |-> (!rf_we && !rf_re && !sdo_oe));

  // R5/R6: writes only happen in a write frame
  p_we_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> st == ST_WRITE);

  // R3: register reads only happen in a read frame
  p_re_in_read_r3: assert property (@(posedge clk) disable iff (rst)
    rf_re |-> st == ST_READ);
endmodule

bind spi_rb_slave spi_rb_checker u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .st(st_q),
  .rf_re(rf_re), .rf_we(rf_we), .sdo_oe(sdo_oe)
);

// File: tb/sim_spi_rb_slave.sv
module sim_spi_rb_slave;
  localparam int HP = 10;
  localparam int NV = 8;
  // {command[15:0], word count[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {16'hE405, 4'd3},  // read 0x005
    {16'hE7FE, 4'd3},  // read 0x3FE, wraps
    {16'hE100, 4'd2},  // write 0x100
    {16'hA405, 4'd2},  // bad key, read
    {16'hE500, 4'd2},  // read back 0x100
    {16'hF007, 4'd2},  // bad key, write
    {16'hE3FF, 4'd2},  // write 0x3FF, wraps
    {16'hE7FF, 4'd2}   // read back across wrap
  };

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe, rf_re, rf_we;
  logic [9:0] rf_addr;
  logic [15:0] rf_wdata, rf_rdata;
  logic [15:0] mem [1024];
  logic [15:0] ref_mem [1024];
  int n_chk = 0, n_fail = 0, we_cnt = 0;

  always #2 clk = ~clk;

  spi_rb_slave u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .rf_addr(rf_addr), .rf_re(rf_re),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [15:0] init_val(input logic [9:0] a);
    return {a[5:0], a} ^ 16'h9E37;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_val(10'(i));
      rf_rdata <= '0;
    end else begin
      if (rf_we) begin
        mem[rf_addr] <= rf_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (rf_re) rf_rdata <= mem[rf_addr];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic o, output logic e);
    sdi = b;
    repeat (HP) @(negedge clk);
    sclk = 1;
    o = sdo;
    e = sdo_oe;
    repeat (HP) @(negedge clk);
    sclk = 0;
  endtask

  task automatic word_xfer(input logic [15:0] w, input int nbits, output logic [15:0] r,
                           output logic any_oe, output logic all_oe);
    logic o, e;
    r = '0; any_oe = 0; all_oe = 1;
    for (int i = 15; i > 15 - nbits; i--) begin
      bit_xfer(w[i], o, e);
      r[i] = o;
      any_oe |= e;
      all_oe &= e;
    end
  endtask

  task automatic sel;
    cs_n = 0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic desel;
    repeat (HP) @(negedge clk);
    cs_n = 1;
    repeat (2 * HP) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic ao, lo;
    int we0;
    for (int i = 0; i < 1024; i++) ref_mem[i] = init_val(10'(i));
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!sdo_oe && !rf_re && !rf_we, "R9 reset", {rf_re, rf_we, sdo_oe}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] cmd;
      logic [9:0] a;
      int nw;
      bit good, rd;
      cmd = VEC[v][19:4];
      nw = int'(VEC[v][3:0]);
      a = cmd[9:0];
      good = (cmd[15:11] == 5'b11100);   // R1 key field
      rd = cmd[10];
      we0 = we_cnt;
      sel();
      word_xfer(cmd, 16, r, ao, lo);
      check(!ao, "R4 oe during command", 32'(ao), 0);
      for (int k = 0; k < nw; k++) begin
        logic [9:0] ak;
        logic [15:0] wd;
        ak = a + 10'(k);
        wd = 16'hC3A0 + 16'(v * 16 + k);
        word_xfer(rd ? 16'hFFFF : wd, 16, r, ao, lo);
        if (!good) begin
          check(!ao, "R2 bad key keeps output off", 32'(ao), 0);
        end else if (rd) begin
          // R1/R3: stream of consecutive registers, R7 when past 0x3FF
          check(r == ref_mem[ak] && lo, (32'(a) + k > 1023) ? "R7 read wrap" : "R3 read stream",
                {15'd0, lo, r}, {16'd1, ref_mem[ak]});
        end else begin
          ref_mem[ak] = wd;
        end
      end
      desel();
      check(!sdo_oe, "R4 oe after deselect", 32'(sdo_oe), 0);
      if (!good || rd) begin
        // R5 (read stream with SDI high) and R2 (bad key): no writes
        check(we_cnt == we0, good ? "R5 sdi ignored in read" : "R2 bad key no write", we_cnt - we0, 0);
      end
      for (int k = 0; k < nw; k++) begin
        logic [9:0] ak;
        ak = a + 10'(k);
        if (good && !rd)
          check(mem[ak] == ref_mem[ak], (32'(a) + k > 1023) ? "R7 write wrap" : "R6 write",
                mem[ak], ref_mem[ak]);
        else if (!good)
          check(mem[ak] == ref_mem[ak], "R2 bad key memory", mem[ak], ref_mem[ak]);
      end
    end

    // R8: abort after 9 command bits, then a full read must decode cleanly
    sel();
    word_xfer(16'hE5FF, 9, r, ao, lo);
    desel();
    sel();
    word_xfer(16'hE600, 16, r, ao, lo);  // read 0x200
    word_xfer(16'hFFFF, 16, r, ao, lo);
    desel();
    check(r == ref_mem[10'h200], "R8 restart after abort", r, ref_mem[10'h200]);

    // R6: a partial data word is not written
    we0 = we_cnt;
    sel();
    word_xfer(16'hE10A, 16, r, ao, lo);
    word_xfer(16'h1234, 7, r, ao, lo);
    desel();
    check(we_cnt == we0, "R6 partial word write count", we_cnt - we0, 0);
    check(mem[10'h10A] == ref_mem[10'h10A], "R6 partial word memory", mem[10'h10A], ref_mem[10'h10A]);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule